// File: doc/BRIEF.md
# Single-Wire Bus Slave Acknowledge Controller

This block is the slave-side framing and acknowledge engine for a single-wire serial memory bus on which every bit is Manchester coded. It follows the bit grid from the moment a start-header strobe arrives. It shifts in each byte the master sends, samples the master's acknowledge bit, and then either drives its own acknowledge or leaves the line alone for that bit period. A slave that leaves the line alone produces no mid-bit edge, and the master reads that as a negative acknowledge.

From the first two bytes of each transaction the controller decides whether it is the addressed device and whether the command may run. It also keeps a write-busy flag. When a write-type command is ended correctly, it raises a one-cycle start strobe toward the memory core. The memory array, the per-command datapath, detection of the standby pulse and of the start header, and the line driver itself lie outside the block. The two detections reach it as strobes, and the driver is controlled through an enable and a level.

Top module: `sw_ack_ctrl`

## Requirements
- R1: After reset the line is released (`sio_oe`=0), `wr_start`=0 and `wr_busy`=0. The controller ignores start-header strobes until it has seen a standby strobe.
- R2: A bit is read from the two half-period samples at one quarter and three quarters of a `CLKS_PER_BIT` period. Low then high is a '1'; high then low is a '0'. An acknowledge is driven for the whole slave bit period, low in the first half and high in the second. A negative acknowledge keeps `sio_oe` at 0 for the whole period.
- R3: The slave bit after the start header is always a negative acknowledge. If the master bit there is '1' the transaction goes on. If it is '0' the controller goes idle.
- R4: The byte after the header is acknowledged only if it is 8'hA0: upper nibble 4'b1010, lower nibble 4'b0000. Any other value gets a negative acknowledge.
- R5: A master '0' right after a matching address byte is acknowledged and ends the transaction. A new start header is then accepted without a standby strobe.
- R6: The third byte is a command. Valid codes are 8'h03 read, 8'h06 sequential read, 8'h6C write, 8'h6E status write, 8'h05 status read, 8'h6D erase all, 8'h67 set all, 8'h96 write enable and 8'h91 write disable. Any other code gets a negative acknowledge.
- R7: While `wr_busy` is 1, the codes 8'h03, 8'h06, 8'h6C, 8'h6E, 8'h6D and 8'h67 are treated as invalid and get a negative acknowledge. 8'h05, 8'h96 and 8'h91 are still acknowledged.
- R8: A master '1' after the command byte or any later byte is acknowledged. A master '0' after byte k is acknowledged only if k has reached the command's minimum; otherwise it gets a negative acknowledge. Bytes are numbered header=0, address=1, command=2. The minimums are: 8'h6D, 8'h67, 8'h96 and 8'h91 need 2; 8'h06, 8'h05 and 8'h6E need 3; 8'h03 and 8'h6C need 4.
- R9: An acknowledged master '0' that ends 8'h6C, 8'h6E, 8'h6D or 8'h67 raises `wr_start` for one cycle and sets `wr_busy`, both visible one clock after the three-quarter sample of the master bit.
- R10: A write (8'h6C) or status write (8'h6E) ended before any data byte has arrived gets a negative acknowledge and starts no write cycle.
- R11: `wr_busy` clears on the clock edge that samples `wr_done`=1, unless a write starts on that same edge.
- R12: After a negative acknowledge other than the one after the header, or after a master bit with no mid-bit edge, the controller goes idle. It then needs a standby strobe and a new start-header strobe. A standby strobe in any state releases the line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sio_in | input | 1 | Synchronized level of the bus line |
| stby_stb | input | 1 | One-cycle strobe: standby pulse seen |
| hdr_stb | input | 1 | One-cycle strobe: start header done; the next cycle opens the header's master-acknowledge bit |
| wr_done | input | 1 | Memory core finished its write cycle |
| sio_oe | output | 1 | Drive enable for the bus line |
| sio_out | output | 1 | Level driven when `sio_oe` is 1 |
| wr_start | output | 1 | One-cycle request to start an internal write cycle |
| wr_busy | output | 1 | A write cycle is in progress |

## Verification
A wrong bit-slot or byte count moves the acknowledge window. `sio_oe` then rises during a master bit, or fails to rise in the slave bit. This shows in the very first acknowledge slot after the fault, at most ten bit periods later. A stale busy flag or a wrongly stored command shows as a missing or extra acknowledge at the next command byte. It can also show as `wr_start` appearing in the wrong cycle of the ending master bit. The reference model predicts `sio_oe`, `sio_out`, `wr_start` and `wr_busy` on every clock, so a single-cycle shift of the drive window is caught.

// File: rtl/sw_ack_pkg.sv
// Shared types and constants of the single-wire acknowledge controller.
// Assumes byte transfers MSB first and a ten-slot frame (8 data, 1 master ack, 1 slave ack).
package sw_ack_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for a standby strobe
        PH_READY = 2'd1,   // waiting for a start-header strobe
        PH_RUN   = 2'd2    // following the bit grid
    } phase_t;

    typedef enum logic [1:0] {
        NX_GO    = 2'd0,   // next byte follows
        NX_READY = 2'd1,   // transaction ended cleanly
        NX_IDLE  = 2'd2    // transaction ended with an error
    } next_t;

    localparam int          SLOT_W   = 4;
    localparam logic [3:0]  SLOT_MAK = 4'd8;
    localparam logic [3:0]  SLOT_SAK = 4'd9;

    localparam logic [7:0]  OP_READ  = 8'h03;
    localparam logic [7:0]  OP_SREAD = 8'h06;
    localparam logic [7:0]  OP_WRITE = 8'h6C;
    localparam logic [7:0]  OP_SWR   = 8'h6E;
    localparam logic [7:0]  OP_SRD   = 8'h05;
    localparam logic [7:0]  OP_CLR   = 8'h6D;
    localparam logic [7:0]  OP_SET   = 8'h67;
    localparam logic [7:0]  OP_WEN   = 8'h96;
    localparam logic [7:0]  OP_WDI   = 8'h91;

endpackage

// File: rtl/sw_ack_bit_timer.sv
// Bit-period timer: counts clocks inside one bit and flags the sample and end points.
// Assumes CPB >= 8 so that the sample points and the bit end fall in distinct cycles.
module sw_ack_bit_timer #(
    parameter int CPB = 16,
    localparam int CW   = $clog2(CPB),
    localparam int QTR  = CPB / 4,
    localparam int HALF = CPB / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    output logic          smp_a,
    output logic          smp_b,
    output logic          bit_end,
    output logic          late_half
);

    logic [CW-1:0] cnt;

    // Position counter inside the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == CW'(CPB - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // Decode of the interesting positions.
    always_comb begin
        smp_a     = run && (cnt == CW'(QTR));
        smp_b     = run && (cnt == CW'(3 * QTR));
        bit_end   = run && (cnt == CW'(CPB - 1));
        late_half = (cnt >= CW'(HALF));
    end

endmodule

// File: rtl/sw_ack_mbit_sampler.sv
// Manchester bit sampler: keeps the first-half level and, at the second sample,
// reports the bit value and whether a mid-bit transition was present.
// Assumes the line input is already synchronized to clk.
module sw_ack_mbit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic smp_a,
    input  logic smp_b,
    output logic bit_rdy,
    output logic bit_val,
    output logic bit_ok
);

    logic first_lvl;

    // Hold the level seen in the first half of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_lvl <= 1'b0;
        end else if (smp_a) begin
            first_lvl <= line;
        end
    end

    // A bit is valid only if the two halves differ; its value is the late level.
    always_comb begin
        bit_rdy = smp_b;
        bit_val = line;
        bit_ok  = (first_lvl != line);
    end

endmodule

// File: rtl/sw_ack_cmd_policy.sv
// Command and address policy: address match, command legality, busy gating,
// minimum byte count for a clean end and the write-type class.
// Purely combinational; the caller picks which code is judged.
module sw_ack_cmd_policy #(
    parameter int         KW     = 3,
    parameter logic [3:0] FAMILY = 4'b1010,
    parameter logic [3:0] DEVSEL = 4'b0000
) (
    input  logic [7:0]    addr_byte,
    input  logic [7:0]    code,
    input  logic [KW-1:0] k,
    output logic          addr_ok,
    output logic          known,
    output logic          busy_bar,
    output logic          is_write,
    output logic          end_ok
);
    import sw_ack_pkg::*;

    int min_k;

    // Classify the command code.
    always_comb begin
        known    = 1'b1;
        busy_bar = 1'b0;
        is_write = 1'b0;
        min_k    = 2;
        case (code)
            OP_READ:  begin busy_bar = 1'b1; min_k = 4; end
            OP_SREAD: begin busy_bar = 1'b1; min_k = 3; end
            OP_WRITE: begin busy_bar = 1'b1; is_write = 1'b1; min_k = 4; end
            OP_SWR:   begin busy_bar = 1'b1; is_write = 1'b1; min_k = 3; end
            OP_CLR:   begin busy_bar = 1'b1; is_write = 1'b1; end
            OP_SET:   begin busy_bar = 1'b1; is_write = 1'b1; end
            OP_SRD:   min_k = 3;
            OP_WEN:   min_k = 2;
            OP_WDI:   min_k = 2;
            default:  known = 1'b0;
        endcase
        addr_ok = (addr_byte[7:4] == FAMILY) && (addr_byte[3:0] == DEVSEL);
        end_ok  = known && (int'(k) >= min_k);
    end

endmodule

// File: rtl/sw_ack_ctrl.sv
// Top of the slave acknowledge controller. Follows the bit grid after a header
// strobe, shifts in bytes, decides the slave acknowledge after each master
// acknowledge bit, drives it Manchester coded and requests write cycles.
// Assumes sio_in is synchronized and that header/standby detection is external.
module sw_ack_ctrl #(
    parameter int         CLKS_PER_BIT = 16,
    parameter int         KW           = 3,
    parameter logic [3:0] FAMILY       = 4'b1010,
    parameter logic [3:0] DEVSEL       = 4'b0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sio_in,
    input  logic stby_stb,
    input  logic hdr_stb,
    input  logic wr_done,
    output logic sio_oe,
    output logic sio_out,
    output logic wr_start,
    output logic wr_busy
);
    import sw_ack_pkg::*;

    phase_t              phase;
    next_t               nx_q, dec_nx;
    logic [SLOT_W-1:0]   slot;
    logic [KW-1:0]       k;
    logic [7:0]          shreg, cmd_q, code_sel;
    logic                sak_q, dec_sak, dec_commit;
    logic                smp_a, smp_b, bit_end, late_half;
    logic                bit_rdy, bit_val, bit_ok;
    logic                addr_ok, known, busy_bar, is_write, end_ok, cmd_ok;
    logic                restart, run;

    assign restart = (phase == PH_READY) && hdr_stb && !stby_stb;
    assign run     = (phase == PH_RUN);

    sw_ack_bit_timer #(.CPB(CLKS_PER_BIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
        .smp_a(smp_a), .smp_b(smp_b), .bit_end(bit_end), .late_half(late_half)
    );

    sw_ack_mbit_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .line(sio_in), .smp_a(smp_a), .smp_b(smp_b),
        .bit_rdy(bit_rdy), .bit_val(bit_val), .bit_ok(bit_ok)
    );

    // Judge the fresh byte while it is the command, the stored command afterwards.
    assign code_sel = (k == KW'(2)) ? shreg : cmd_q;

    sw_ack_cmd_policy #(.KW(KW), .FAMILY(FAMILY), .DEVSEL(DEVSEL)) u_pol (
        .addr_byte(shreg), .code(code_sel), .k(k),
        .addr_ok(addr_ok), .known(known), .busy_bar(busy_bar),
        .is_write(is_write), .end_ok(end_ok)
    );

    assign cmd_ok = known && !(wr_busy && busy_bar);

    // Acknowledge decision taken at the second sample of the master bit.
    always_comb begin
        dec_sak    = 1'b0;
        dec_nx     = NX_IDLE;
        dec_commit = 1'b0;
        if (k == '0) begin
            dec_nx = bit_val ? NX_GO : NX_IDLE;
        end else if (k == KW'(1)) begin
            if (addr_ok) begin
                dec_sak = 1'b1;
                dec_nx  = bit_val ? NX_GO : NX_READY;
            end
        end else if ((k == KW'(2)) && !cmd_ok) begin
            dec_nx = NX_IDLE;
        end else if (bit_val) begin
            dec_sak = 1'b1;
            dec_nx  = NX_GO;
        end else if (end_ok) begin
            dec_sak    = 1'b1;
            dec_nx     = NX_READY;
            dec_commit = is_write;
        end
    end

    // Frame sequencing, decision capture and write-busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            nx_q     <= NX_IDLE;
            slot     <= '0;
            k        <= '0;
            shreg    <= '0;
            cmd_q    <= '0;
            sak_q    <= 1'b0;
            wr_start <= 1'b0;
            wr_busy  <= 1'b0;
        end else begin
            wr_start <= 1'b0;
            if (wr_done) begin
                wr_busy <= 1'b0;
            end
            if (stby_stb) begin
                phase <= PH_READY;
                sak_q <= 1'b0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        sak_q <= 1'b0;
                    end
                    PH_READY: begin
                        if (hdr_stb) begin
                            phase <= PH_RUN;
                            slot  <= SLOT_MAK;
                            k     <= '0;
                            sak_q <= 1'b0;
                        end
                    end
                    PH_RUN: begin
                        if (bit_rdy && (slot != SLOT_SAK)) begin
                            if (!bit_ok) begin
                                phase <= PH_IDLE;
                            end else if (slot < SLOT_MAK) begin
                                shreg <= {shreg[6:0], bit_val};
                            end else begin
                                sak_q <= dec_sak;
                                nx_q  <= dec_nx;
                                if (k == KW'(2)) begin
                                    cmd_q <= shreg;
                                end
                                if (dec_commit) begin
                                    wr_start <= 1'b1;
                                    wr_busy  <= 1'b1;
                                end
                            end
                        end else if (bit_end) begin
                            if (slot == SLOT_SAK) begin
                                sak_q <= 1'b0;
                                case (nx_q)
                                    NX_GO: begin
                                        slot <= '0;
                                        if (k != '1) begin
                                            k <= k + 1'b1;
                                        end
                                    end
                                    NX_READY: phase <= PH_READY;
                                    default:  phase <= PH_IDLE;
                                endcase
                            end else begin
                                slot <= slot + 1'b1;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // Line drive: only in the slave slot, low then high.
    always_comb begin
        sio_oe  = run && (slot == SLOT_SAK) && sak_q;
        sio_out = sio_oe && late_half;
    end

endmodule

// File: rtl/sw_ack_ctrl_chk.sv
// Port-level property checker for sw_ack_ctrl, attached with bind below.
// Assumes the synchronous active-low reset of the controller.
module sw_ack_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic stby_stb,
    input logic wr_done,
    input logic sio_oe,
    input logic sio_out,
    input logic wr_start,
    input logic wr_busy
);

    // R9: the write request lasts exactly one cycle.
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

    // R9: the busy flag only rises together with a write request.
    p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> wr_start);

    // R11: a done indication clears busy unless a new write started.
    p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (!wr_busy || wr_start));

    // R2: a driven acknowledge begins with the low half.
    p_sak_low_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sio_oe) |-> !sio_out);

    // R2: once the high half is driven it stays high until release.
    p_sak_high_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe && sio_out) |=> (!sio_oe || sio_out));

    // R12: a standby strobe releases the line on the next cycle.
    p_stby_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stby_stb |=> !sio_oe);

endmodule

bind sw_ack_ctrl sw_ack_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stby_stb(stby_stb), .wr_done(wr_done),
    .sio_oe(sio_oe), .sio_out(sio_out), .wr_start(wr_start), .wr_busy(wr_busy)
);

// File: tb/sim_sw_ack_ctrl.sv
// Bench for sw_ack_ctrl: drives Manchester frames and compares all outputs
// against a behavioural expectation on every clock.
module sim_sw_ack_ctrl;

    localparam int CPB  = 16;
    localparam int HALF = CPB / 2;
    localparam int QTR  = CPB / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sio_in = 1'b1;
    logic stby_stb = 1'b0;
    logic hdr_stb = 1'b0;
    logic wr_done = 1'b0;
    logic sio_oe, sio_out, wr_start, wr_busy;

    int  checks = 0;
    int  fails  = 0;
    bit  m_busy = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    sw_ack_ctrl #(.CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst_n(rst_n), .sio_in(sio_in), .stby_stb(stby_stb),
        .hdr_stb(hdr_stb), .wr_done(wr_done), .sio_oe(sio_oe), .sio_out(sio_out),
        .wr_start(wr_start), .wr_busy(wr_busy)
    );

    // One clock: compare at the falling edge, then drive the next inputs.
    task automatic tick(input logic lvl, input logic eoe, input logic eout,
                        input logic estart, input logic done, input string tag);
        @(negedge clk);
        checks++;
        if (sio_oe !== eoe || sio_out !== eout || wr_start !== estart || wr_busy !== m_busy) begin
            fails++;
            $display("FAIL %s: oe,out,start,busy = %b%b%b%b expected %b%b%b%b at %0t",
                     tag, sio_oe, sio_out, wr_start, wr_busy, eoe, eout, estart, m_busy, $time);
        end
        sio_in   = lvl;
        wr_done  = done;
        hdr_stb  = 1'b0;
        stby_stb = 1'b0;
        if (done) m_busy = 1'b0;
    endtask

    task automatic idle_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic standby(input string tag);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
        stby_stb = 1'b1;
        idle_ticks(2, tag);
    endtask

    // Master-driven bit; commit marks the bit whose end starts a write.
    task automatic send_bit(input logic b, input logic commit, input string tag);
        for (int c = 0; c < CPB; c++) begin
            logic es;
            es = commit && (c == 3 * QTR + 1);
            if (es) m_busy = 1'b1;
            tick((c < HALF) ? ~b : b, 1'b0, 1'b0, es, 1'b0, tag);
        end
    endtask

    // A bit period with no mid-bit transition.
    task automatic bad_bit(input string tag);
        for (int c = 0; c < CPB; c++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Slave slot: expected drive is low then high when acknowledging.
    task automatic sak_slot(input logic esak, input string tag);
        for (int c = 0; c < CPB; c++)
            tick(1'b1, esak, esak && (c >= HALF), 1'b0, 1'b0, tag);
    endtask

    task automatic header(input logic mak, input string tag);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
        hdr_stb = 1'b1;
        send_bit(mak, 1'b0, tag);
        sak_slot(1'b0, tag);
    endtask

    task automatic frame(input logic [7:0] b, input logic mak, input logic esak,
                         input logic commit, input string tag);
        for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b0, tag);
        send_bit(mak, commit, tag);
        sak_slot(esak, tag);
    endtask

    task automatic done_pulse(input string tag);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, tag);
        idle_ticks(2, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then header ignored before standby
        idle_ticks(4, "R1");
        header(1'b1, "R1");
        frame(8'hA0, 1'b1, 1'b0, 1'b0, "R1");

        // R3 R4 R6 R8: status read, clean end after one data byte
        standby("R1");
        header(1'b1, "R3");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R4");
        frame(8'h05, 1'b1, 1'b1, 1'b0, "R6");
        frame(8'h00, 1'b0, 1'b1, 1'b0, "R8");

        // R5: end right after address, new header needs no standby
        header(1'b1, "R5");
        frame(8'hA0, 1'b0, 1'b1, 1'b0, "R5");
        header(1'b1, "R5");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R5");
        frame(8'h96, 1'b0, 1'b1, 1'b0, "R8");

        // R4: wrong device code, then idle until standby (R12)
        header(1'b1, "R4");
        frame(8'hA1, 1'b1, 1'b0, 1'b0, "R4");
        header(1'b1, "R12");
        frame(8'hA0, 1'b1, 1'b0, 1'b0, "R12");
        standby("R12");
        header(1'b1, "R4");
        frame(8'h50, 1'b1, 1'b0, 1'b0, "R4");

        // R6: unknown command
        standby("R6");
        header(1'b1, "R6");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R6");
        frame(8'h55, 1'b1, 1'b0, 1'b0, "R6");

        // R10: write ended after its address byte, no data
        standby("R10");
        header(1'b1, "R10");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R10");
        frame(8'h6C, 1'b1, 1'b1, 1'b0, "R10");
        frame(8'h12, 1'b0, 1'b0, 1'b0, "R10");

        // R9: full write commits
        standby("R9");
        header(1'b1, "R9");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R9");
        frame(8'h6C, 1'b1, 1'b1, 1'b0, "R9");
        frame(8'h12, 1'b1, 1'b1, 1'b0, "R9");
        frame(8'h3C, 1'b0, 1'b1, 1'b1, "R9");

        // R7: read refused while busy, status read allowed
        header(1'b1, "R7");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R7");
        frame(8'h03, 1'b1, 1'b0, 1'b0, "R7");
        standby("R7");
        header(1'b1, "R7");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R7");
        frame(8'h05, 1'b1, 1'b1, 1'b0, "R7");
        frame(8'h80, 1'b0, 1'b1, 1'b0, "R7");

        // R11: done clears busy
        done_pulse("R11");

        // R9: erase-all at byte 2, status write with one data byte
        header(1'b1, "R9");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R9");
        frame(8'h6D, 1'b0, 1'b1, 1'b1, "R9");
        done_pulse("R11");
        header(1'b1, "R9");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R9");
        frame(8'h6E, 1'b1, 1'b1, 1'b0, "R9");
        frame(8'h0C, 1'b0, 1'b1, 1'b1, "R9");
        done_pulse("R11");

        // R10: status write ended with no data byte
        header(1'b1, "R10");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R10");
        frame(8'h6E, 1'b0, 1'b0, 1'b0, "R10");

        // R8: read ended too early, then ended after one data byte
        standby("R8");
        header(1'b1, "R8");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R8");
        frame(8'h03, 1'b1, 1'b1, 1'b0, "R8");
        frame(8'h10, 1'b0, 1'b0, 1'b0, "R8");
        standby("R8");
        header(1'b1, "R8");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R8");
        frame(8'h03, 1'b1, 1'b1, 1'b0, "R8");
        frame(8'h10, 1'b1, 1'b1, 1'b0, "R8");
        frame(8'hFF, 1'b0, 1'b1, 1'b0, "R8");

        // R3: master '0' after header sends the slave idle
        header(1'b0, "R3");
        header(1'b1, "R3");
        frame(8'hA0, 1'b1, 1'b0, 1'b0, "R3");

        // R12: a master bit without mid-bit edge sends the slave idle
        standby("R12");
        header(1'b1, "R12");
        bad_bit("R12");
        frame(8'hA0, 1'b1, 1'b0, 1'b0, "R12");
        standby("R12");
        header(1'b1, "R12");
        frame(8'hA0, 1'b1, 1'b1, 1'b0, "R12");

        // R2 R12: standby in the middle of a frame releases and re-arms
        standby("R2");
        idle_ticks(4, "R2");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule